// File: doc/BRIEF.md
# HyperBus Manual Transfer Sequencer

This block runs a single HyperBus transaction on behalf of a host processor. Software fills a small register file with a command, a byte address, a transfer-size code, a latency count and, for writes, up to 64 bits of outgoing data. A write to the control register then launches the transaction. The engine sends a 48-bit command-address word over three bus cycles, waits out the programmed latency on reads, and moves one, two or four 16-bit data beats.

Each bus cycle carries 16 bits at double data rate. The upper byte rides the rising-edge lane and the lower byte rides the falling-edge lane. Read beats are assembled into a 64-bit holding register in big-endian order. A status bit tells software when the engine is idle again. The engine takes a snapshot of every setting when the transfer starts, so software can prepare the next transaction while the current one is still running.

Register map (index on `reg_idx` / `reg_ridx`): 0 command, 1 byte address, 2 format, 3 control (write only), 4 write data bits 63:32, 5 write data bits 31:0, 6 read data bits 63:32, 7 read data bits 31:0, 8 status. Any other read index returns zero.

Top module: `hb_xfer_engine`

## Requirements
- R1: After reset, `hb_cs_n` is 1, `hb_dq_oe` is 0, both output lanes are 0, status bit 0 reads 1, and both read-data registers read 0.
- R2: A transfer starts only when control (index 3) is written while idle with bit 0 (go) set and exactly one of bit 1 (write) or bit 2 (read) set. Every other combination leaves the bus idle.
- R3: The command-address word is sent in three consecutive cycles, with bits 47:32 first, then 31:16, then 15:0. CA[47:45] equals command bits 7:5, so command bit 7 = 1 means read and 0 means write. With word address W = byte address >> 1, CA[44:16] = W[31:3], CA[15:3] = 0 and CA[2:0] = W[2:0].
- R4: In every driven cycle, bits 15:8 of the bus word appear on `hb_dq_rise_o` and bits 7:0 on `hb_dq_fall_o`. Read beats are taken as {`hb_dq_rise_i`, `hb_dq_fall_i`}.
- R5: A read inserts exactly N latency cycles after the address, where N is format bits 11:8. During these cycles the select stays active and the bus is not driven. N = 0 inserts none, and writes never insert latency.
- R6: Format bits 3:0 select the beat count: 0xF gives four beats, 0xC gives two, and 0x8 or any other code gives one.
- R7: Write beats are taken from the 64-bit write data, most significant 16 bits first (index 4 bits 31:16 form the first beat).
- R8: Read beat k (counted from 0) lands in read-data bits 63-16k down to 48-16k. A read clears the whole read-data register at its start, so any bits it does not fill read 0.
- R9: `hb_cs_n` is 0 from the first address cycle through the last data beat and returns to 1 in the next cycle. While it is 1, `hb_dq_oe` and both lanes are 0.
- R10: Status bit 0 (index 8) reads 0 from the cycle after an accepted start until the last beat, and 1 otherwise. Its other bits read 0.
- R11: A control write that arrives while a transfer runs is ignored. It neither restarts nor extends the transfer.
- R12: Writes to the command, address, format or write-data registers during a transfer do not alter that transfer, and they do take effect for the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for writes |
| reg_wdata | input | 32 | Register write data |
| reg_ridx | input | 4 | Register index for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| hb_cs_n | output | 1 | Bus chip select, active low |
| hb_dq_oe | output | 1 | Bus data output enable |
| hb_dq_rise_o | output | 8 | Byte driven on the rising clock edge |
| hb_dq_fall_o | output | 8 | Byte driven on the falling clock edge |
| hb_dq_rise_i | input | 8 | Byte received on the rising clock edge |
| hb_dq_fall_i | input | 8 | Byte received on the falling clock edge |

## Verification
The assertions check the following on every cycle: the bus stays quiet while deselected; the output enable never rises without the select; a selected period spans at least the three address cycles plus one beat; the status bit mirrors the select; and a control write taken while idle starts a transfer only when its encoding is legal. Some properties can only be shown by the bench's scenarios against its cycle-by-cycle model. These are the exact address-word layout, the latency length per format, the beat count per size code, big-endian assembly and clearing of read data, rejection of starts during a transfer, and the snapshot behaviour when registers change mid-transfer.

// File: rtl/hb_pkg.sv
// Shared constants and helpers for the HyperBus transfer sequencer.
// Assumes a 32-bit register bus and a 48-bit command-address word.
package hb_pkg;

    localparam int REG_IDX_W = 4;
    localparam int CA_W      = 48;
    localparam int SIZE_W    = 4;
    localparam int CMD_HI_W  = 3;

    localparam logic [REG_IDX_W-1:0] IDX_CMD  = 4'd0;
    localparam logic [REG_IDX_W-1:0] IDX_ADDR = 4'd1;
    localparam logic [REG_IDX_W-1:0] IDX_FMT  = 4'd2;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL = 4'd3;
    localparam logic [REG_IDX_W-1:0] IDX_WHI  = 4'd4;
    localparam logic [REG_IDX_W-1:0] IDX_WLO  = 4'd5;
    localparam logic [REG_IDX_W-1:0] IDX_RHI  = 4'd6;
    localparam logic [REG_IDX_W-1:0] IDX_RLO  = 4'd7;
    localparam logic [REG_IDX_W-1:0] IDX_STAT = 4'd8;

    localparam int CTRL_GO = 0;
    localparam int CTRL_WR = 1;
    localparam int CTRL_RD = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CA   = 2'd1,
        ST_LAT  = 2'd2,
        ST_DATA = 2'd3
    } hb_state_t;

    // Index of the final data beat for a size code (0xF:3, 0xC:1, else 0).
    function automatic logic [1:0] size_last(input logic [SIZE_W-1:0] code);
        case (code)
            4'hF:    return 2'd3;
            4'hC:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // Pack command bits 7:5 and the 31-bit word address into the CA word.
    function automatic logic [CA_W-1:0] build_ca(input logic [CMD_HI_W-1:0] cmd_hi,
                                                 input logic [30:0] waddr);
        return {cmd_hi, 1'b0, waddr[30:3], 13'b0, waddr[2:0]};
    endfunction

endpackage

// File: rtl/hb_regs.sv
// Register file of the sequencer: holds the transfer settings, decodes a
// legal start request and serves the read-data and status registers.
// Assumes one register write per cycle and a combinational read port.
module hb_regs
    import hb_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int DATA_W  = 64,
    parameter int DUMMY_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [REG_IDX_W-1:0] reg_ridx,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 busy,
    input  logic [DATA_W-1:0]    rdata,
    output logic [CMD_HI_W-1:0]  cmd_hi_q,
    output logic [REG_W-2:0]     waddr_q,
    output logic [SIZE_W-1:0]    size_q,
    output logic [DUMMY_W-1:0]   dummy_q,
    output logic [DATA_W-1:0]    wdata_q,
    output logic                 start,
    output logic                 start_rd
);

    localparam int DUMMY_LSB = 8;

    // Hold the settings software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_hi_q <= '0;
            waddr_q  <= '0;
            size_q   <= '0;
            dummy_q  <= '0;
            wdata_q  <= '0;
        end else if (reg_wr) begin
            case (reg_idx)
                IDX_CMD:  cmd_hi_q <= reg_wdata[7:5];
                IDX_ADDR: waddr_q  <= reg_wdata[REG_W-1:1];
                IDX_FMT: begin
                    size_q  <= reg_wdata[SIZE_W-1:0];
                    dummy_q <= reg_wdata[DUMMY_LSB +: DUMMY_W];
                end
                IDX_WHI:  wdata_q[DATA_W-1 -: REG_W] <= reg_wdata;
                IDX_WLO:  wdata_q[REG_W-1:0]         <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Accept a start only while idle and with a legal direction encoding.
    assign start = reg_wr && (reg_idx == IDX_CTRL) && reg_wdata[CTRL_GO]
                   && (reg_wdata[CTRL_WR] ^ reg_wdata[CTRL_RD]) && !busy;
    assign start_rd = reg_wdata[CTRL_RD];

    // Serve the read-only registers.
    always_comb begin
        case (reg_ridx)
            IDX_RHI:  reg_rdata = rdata[DATA_W-1 -: REG_W];
            IDX_RLO:  reg_rdata = rdata[REG_W-1:0];
            IDX_STAT: reg_rdata = {{(REG_W-1){1'b0}}, !busy};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hb_seq.sv
// Phase sequencer: snapshots the settings at start, then walks through the
// address, latency and data phases, one 16-bit bus word per cycle.
// Assumes start is raised only while idle.
module hb_seq
    import hb_pkg::*;
#(
    parameter int BEAT_W  = 16,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 32,
    parameter int DUMMY_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_rd,
    input  logic [CMD_HI_W-1:0]  cmd_hi,
    input  logic [ADDR_W-2:0]    waddr,
    input  logic [SIZE_W-1:0]    size,
    input  logic [DUMMY_W-1:0]   dummy,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [BEAT_W-1:0]    din,
    output logic                 busy,
    output logic                 cs_n,
    output logic                 oe,
    output logic [BEAT_W-1:0]    dout,
    output logic [DATA_W-1:0]    rdata
);

    localparam int NBEAT  = DATA_W / BEAT_W;
    localparam int NCA    = CA_W / BEAT_W;
    localparam int BIDX_W = $clog2(NBEAT);
    localparam int CNT_W  = DUMMY_W;

    hb_state_t          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CA_W-1:0]    ca_q;
    logic [DATA_W-1:0]  wbuf_q;
    logic [BIDX_W-1:0]  last_q;
    logic [DUMMY_W-1:0] dummy_q;
    logic               rd_q;
    logic [BEAT_W-1:0]  wbeat [NBEAT];
    logic [BIDX_W-1:0]  bidx;

    assign bidx = cnt_q[BIDX_W-1:0];

    // Advance the phase state and counter; snapshot settings at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ca_q    <= '0;
            wbuf_q  <= '0;
            last_q  <= '0;
            dummy_q <= '0;
            rd_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_CA;
                    cnt_q   <= '0;
                    ca_q    <= build_ca(cmd_hi, waddr);
                    wbuf_q  <= wdata;
                    last_q  <= BIDX_W'(size_last(size));
                    dummy_q <= dummy;
                    rd_q    <= start_rd;
                end
                ST_CA: if (cnt_q == CNT_W'(NCA - 1)) begin
                    cnt_q   <= '0;
                    state_q <= (rd_q && dummy_q != '0) ? ST_LAT : ST_DATA;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_LAT: if (cnt_q == dummy_q - DUMMY_W'(1)) begin
                    cnt_q   <= '0;
                    state_q <= ST_DATA;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                default: if (bidx == last_q) begin
                    cnt_q   <= '0;
                    state_q <= ST_IDLE;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            endcase
        end
    end

    // One slice per beat: write beats from the snapshot, read beats captured.
    for (genvar g = 0; g < NBEAT; g++) begin : g_beat
        logic [BEAT_W-1:0] rbeat_q;

        // Clear on read start; capture the bus word in this beat's cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rbeat_q <= '0;
            else if (state_q == ST_IDLE && start && start_rd)
                rbeat_q <= '0;
            else if (state_q == ST_DATA && rd_q && bidx == BIDX_W'(g))
                rbeat_q <= din;
        end

        assign rdata[DATA_W-1-g*BEAT_W -: BEAT_W] = rbeat_q;
        assign wbeat[g] = wbuf_q[DATA_W-1-g*BEAT_W -: BEAT_W];
    end

    // Choose the bus word and drive enable for the current phase.
    always_comb begin
        dout = '0;
        oe   = 1'b0;
        case (state_q)
            ST_CA: begin
                oe = 1'b1;
                case (cnt_q[1:0])
                    2'd0:    dout = ca_q[CA_W-1 -: BEAT_W];
                    2'd1:    dout = ca_q[CA_W-1-BEAT_W -: BEAT_W];
                    default: dout = ca_q[BEAT_W-1:0];
                endcase
            end
            ST_DATA: if (!rd_q) begin
                oe   = 1'b1;
                dout = wbeat[bidx];
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign cs_n = !busy;

endmodule

// File: rtl/hb_ddr_pins.sv
// DDR pin model: splits a 16-bit bus word into a rising-edge byte and a
// falling-edge byte, and joins received bytes back into a word.
// Assumes one full bus clock period per system clock cycle.
module hb_ddr_pins #(
    parameter int LANE_W = 8
) (
    input  logic [2*LANE_W-1:0] word_o,
    input  logic                oe,
    output logic [LANE_W-1:0]   rise_o,
    output logic [LANE_W-1:0]   fall_o,
    input  logic [LANE_W-1:0]   rise_i,
    input  logic [LANE_W-1:0]   fall_i,
    output logic [2*LANE_W-1:0] word_i
);

    // Drive the lanes only when enabled; the first byte rides the rising edge.
    assign rise_o = oe ? word_o[2*LANE_W-1:LANE_W] : '0;
    assign fall_o = oe ? word_o[LANE_W-1:0]        : '0;

    // Rebuild the received word, rising-edge byte most significant.
    assign word_i = {rise_i, fall_i};

endmodule

// File: rtl/hb_xfer_engine.sv
// Top of the HyperBus manual transfer sequencer: register file, phase
// sequencer and DDR pin model. Synchronous active-low reset.
module hb_xfer_engine #(
    parameter int REG_W   = 32,
    parameter int DATA_W  = 64,
    parameter int LANE_W  = 8,
    parameter int DUMMY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [3:0]        reg_ridx,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              hb_cs_n,
    output logic              hb_dq_oe,
    output logic [LANE_W-1:0] hb_dq_rise_o,
    output logic [LANE_W-1:0] hb_dq_fall_o,
    input  logic [LANE_W-1:0] hb_dq_rise_i,
    input  logic [LANE_W-1:0] hb_dq_fall_i
);

    localparam int BEAT_W = 2 * LANE_W;

    logic                busy;
    logic [DATA_W-1:0]   rdata;
    logic [2:0]          cmd_hi;
    logic [REG_W-2:0]    waddr;
    logic [3:0]          size;
    logic [DUMMY_W-1:0]  dummy;
    logic [DATA_W-1:0]   wdata;
    logic                start;
    logic                start_rd;
    logic [BEAT_W-1:0]   word_out;
    logic [BEAT_W-1:0]   word_in;

    hb_regs #(.REG_W(REG_W), .DATA_W(DATA_W), .DUMMY_W(DUMMY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
        .busy(busy), .rdata(rdata), .cmd_hi_q(cmd_hi), .waddr_q(waddr),
        .size_q(size), .dummy_q(dummy), .wdata_q(wdata),
        .start(start), .start_rd(start_rd)
    );

    hb_seq #(.BEAT_W(BEAT_W), .DATA_W(DATA_W), .ADDR_W(REG_W), .DUMMY_W(DUMMY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .cmd_hi(cmd_hi), .waddr(waddr), .size(size), .dummy(dummy),
        .wdata(wdata), .din(word_in), .busy(busy), .cs_n(hb_cs_n),
        .oe(hb_dq_oe), .dout(word_out), .rdata(rdata)
    );

    hb_ddr_pins #(.LANE_W(LANE_W)) u_pins (
        .word_o(word_out), .oe(hb_dq_oe), .rise_o(hb_dq_rise_o),
        .fall_o(hb_dq_fall_o), .rise_i(hb_dq_rise_i), .fall_i(hb_dq_fall_i),
        .word_i(word_in)
    );

endmodule

// File: rtl/hb_xfer_checker.sv
// Checker for the transfer sequencer's port behaviour, attached by bind.
// Assumes the default register map (control at index 3, status at index 8).
module hb_xfer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_idx,
    input logic [2:0]  ctrl_bits,
    input logic [3:0]  reg_ridx,
    input logic [31:0] reg_rdata,
    input logic        hb_cs_n,
    input logic        hb_dq_oe,
    input logic [7:0]  hb_dq_rise_o,
    input logic [7:0]  hb_dq_fall_o
);

    logic legal_ctrl;
    assign legal_ctrl = reg_wr && reg_idx == 4'd3 && ctrl_bits[0] && (ctrl_bits[1] ^ ctrl_bits[2]);

    // R9: a deselected bus is quiet.
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hb_cs_n |-> (!hb_dq_oe && hb_dq_rise_o == 8'h00 && hb_dq_fall_o == 8'h00));

    // R9: driving needs the select.
    assert_oe_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hb_dq_oe |-> !hb_cs_n);

    // R3: the first selected cycle is a driven address cycle.
    assert_ca_driven_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hb_cs_n) |-> hb_dq_oe);

    // R3: address phase plus at least one beat keeps the select for four cycles.
    assert_min_select_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hb_cs_n) |=> !hb_cs_n ##1 !hb_cs_n ##1 !hb_cs_n);

    // R10: the status register mirrors the idle select.
    assert_status_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ridx == 4'd8) |-> (reg_rdata == {31'b0, hb_cs_n}));

    // R2: a legal start while idle selects the bus next cycle.
    assert_start_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_ctrl && hb_cs_n) |=> !hb_cs_n);

    // R2: an illegal control encoding while idle leaves the bus idle.
    assert_bad_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 4'd3 && !legal_ctrl && hb_cs_n) |=> hb_cs_n);

endmodule

bind hb_xfer_engine hb_xfer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .ctrl_bits(reg_wdata[2:0]), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
    .hb_cs_n(hb_cs_n), .hb_dq_oe(hb_dq_oe), .hb_dq_rise_o(hb_dq_rise_o),
    .hb_dq_fall_o(hb_dq_fall_o)
);

// File: tb/hb_xfer_engine_tb.sv
// Bench: behavioural bus model with an expected-cycle queue compared on
// every clock, plus register checks for status and read data.
module hb_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_ridx = '0;
    logic [31:0] reg_rdata;
    logic        hb_cs_n, hb_dq_oe;
    logic [7:0]  hb_dq_rise_o, hb_dq_fall_o;
    logic [7:0]  hb_dq_rise_i = '0, hb_dq_fall_i = '0;

    int errs = 0;
    int checks = 0;

    // Expected bus cycles: [18] address cycle, [17] driven, [16] read beat, [15:0] word.
    logic [18:0] exp_q[$];
    logic [18:0] e;
    bit          act_now = 1'b0;
    bit          model_on = 1'b0;
    string       ctx = "R1";

    logic [7:0]  sh_cmd = '0;
    logic [31:0] sh_addr = '0;
    logic [3:0]  sh_size = '0;
    logic [3:0]  sh_dummy = '0;
    logic [63:0] sh_wdata = '0;
    logic [63:0] exp_rd = '0;
    logic [15:0] rd_seed = '0;

    hb_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
        .hb_cs_n(hb_cs_n), .hb_dq_oe(hb_dq_oe), .hb_dq_rise_o(hb_dq_rise_o),
        .hb_dq_fall_o(hb_dq_fall_o), .hb_dq_rise_i(hb_dq_rise_i),
        .hb_dq_fall_i(hb_dq_fall_i)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [47:0] model_ca(input logic [7:0] cmd, input logic [31:0] a);
        logic [47:0] ca;
        logic [31:0] wa;
        wa = a >> 1;
        ca = '0;
        ca[47:45] = cmd[7:5];
        ca[44:16] = wa[31:3];
        ca[2:0]   = wa[2:0];
        return ca;
    endfunction

    // Compare the bus against the expected cycle and play the memory side.
    always @(negedge clk) begin
        if (model_on) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                act_now = 1'b1;
                chk(hb_cs_n == 1'b0, {"R9 select active ", ctx}, 64'(hb_cs_n), 64'd0);
                chk(hb_dq_oe == e[17], {"R5 drive enable ", ctx}, 64'(hb_dq_oe), 64'(e[17]));
                if (e[17])
                    chk({hb_dq_rise_o, hb_dq_fall_o} == e[15:0],
                        e[18] ? {"R3 R4 address word ", ctx} : {"R7 R4 write beat ", ctx},
                        64'({hb_dq_rise_o, hb_dq_fall_o}), 64'(e[15:0]));
                if (e[16]) begin
                    hb_dq_rise_i = e[15:8];
                    hb_dq_fall_i = e[7:0];
                end else begin
                    hb_dq_rise_i = '0;
                    hb_dq_fall_i = '0;
                end
            end else begin
                act_now = 1'b0;
                hb_dq_rise_i = '0;
                hb_dq_fall_i = '0;
                chk(hb_cs_n == 1'b1, {"R9 select idle ", ctx}, 64'(hb_cs_n), 64'd1);
                chk(!hb_dq_oe && hb_dq_rise_o == 0 && hb_dq_fall_o == 0, {"R9 quiet bus ", ctx},
                    64'({hb_dq_oe, hb_dq_rise_o, hb_dq_fall_o}), 64'd0);
            end
        end
    end

    task automatic push_xfer(input bit rd);
        logic [47:0] ca;
        int nb;
        logic [15:0] w;
        ca = model_ca(sh_cmd, sh_addr);
        nb = (sh_size == 4'hF) ? 4 : (sh_size == 4'hC) ? 2 : 1;
        for (int i = 0; i < 3; i++) exp_q.push_back({1'b1, 1'b1, 1'b0, ca[47-16*i -: 16]});
        if (rd) begin
            for (int d = 0; d < int'(sh_dummy); d++) exp_q.push_back(19'd0);
            exp_rd = '0;
        end
        for (int b = 0; b < nb; b++) begin
            if (rd) begin
                w = rd_seed ^ (16'h1111 * 16'(b + 1));
                exp_q.push_back({1'b0, 1'b0, 1'b1, w});
                exp_rd[63-16*b -: 16] = w;
            end else begin
                exp_q.push_back({1'b0, 1'b1, 1'b0, sh_wdata[63-16*b -: 16]});
            end
        end
    endtask

    task automatic reg_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_idx = idx;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        case (idx)
            4'd0: sh_cmd = d[7:0];
            4'd1: sh_addr = d;
            4'd2: begin sh_size = d[3:0]; sh_dummy = d[11:8]; end
            4'd3: if (d[0] && (d[1] ^ d[2]) && !act_now) push_xfer(d[2]);
            4'd4: sh_wdata[63:32] = d;
            4'd5: sh_wdata[31:0] = d;
            default: ;
        endcase
    endtask

    task automatic reg_read_chk(input logic [3:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_ridx = idx;
        #1;
        chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic wait_idle();
        do begin
            @(posedge clk);
            #1;
        end while (exp_q.size() != 0 || act_now);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: state held in reset
        repeat (3) @(posedge clk);
        reg_read_chk(4'd8, 32'd1, "R1 status in reset");
        reg_read_chk(4'd6, 32'd0, "R1 read data hi in reset");
        reg_read_chk(4'd7, 32'd0, "R1 read data lo in reset");
        chk(hb_cs_n == 1'b1 && !hb_dq_oe, "R1 bus idle in reset", 64'({hb_cs_n, hb_dq_oe}), 64'd2);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;

        // 16-bit write; latency field must be skipped on writes (R5, R6 code 0x8)
        ctx = "R5 write";
        reg_write(4'd0, 32'h20);
        reg_write(4'd1, 32'h0002_468A);
        reg_write(4'd2, 32'h0000_0E08);
        reg_write(4'd4, 32'hA5C3_1F2E);
        reg_write(4'd5, 32'h0F0F_5A5A);
        reg_write(4'd3, 32'h3);
        reg_read_chk(4'd8, 32'd0, "R10 status busy");
        wait_idle();
        reg_read_chk(4'd8, 32'd1, "R10 status idle after write");

        // 32-bit read with 14 latency cycles
        ctx = "R8 read32";
        rd_seed = 16'hD00D;
        reg_write(4'd0, 32'hA0);
        reg_write(4'd1, 32'h00FF_FFFE);
        reg_write(4'd2, 32'h0000_0E0C);
        reg_write(4'd3, 32'h5);
        wait_idle();
        reg_read_chk(4'd6, exp_rd[63:32], "R8 read32 upper");
        reg_read_chk(4'd7, 32'd0, "R8 read32 lower cleared");

        // 64-bit read without latency
        ctx = "R6 read64";
        rd_seed = 16'h3C5A;
        reg_write(4'd0, 32'h80);
        reg_write(4'd1, 32'h1234_5677);
        reg_write(4'd2, 32'h0000_000F);
        reg_write(4'd3, 32'h5);
        wait_idle();
        reg_read_chk(4'd6, exp_rd[63:32], "R8 read64 upper");
        reg_read_chk(4'd7, exp_rd[31:0], "R8 read64 lower");

        // 64-bit write; start and setting changes during the transfer
        ctx = "R12 write64";
        reg_write(4'd0, 32'h00);
        reg_write(4'd1, 32'h0000_0010);
        reg_write(4'd4, 32'h0123_4567);
        reg_write(4'd5, 32'h89AB_CDEF);
        reg_write(4'd3, 32'h3);
        ctx = "R11 start while busy";
        reg_write(4'd3, 32'h5);
        ctx = "R12 settings while busy";
        reg_write(4'd1, 32'h0000_0ABC);
        reg_write(4'd4, 32'hFFFF_0000);
        wait_idle();
        reg_read_chk(4'd6, exp_rd[63:32], "R11 read data untouched by ignored start");

        // Changed settings apply to the next transfer
        ctx = "R12 next transfer";
        reg_write(4'd3, 32'h3);
        wait_idle();

        // Illegal control encodings
        ctx = "R2 illegal start";
        reg_write(4'd3, 32'h7);
        reg_read_chk(4'd8, 32'd1, "R2 both directions ignored");
        reg_write(4'd3, 32'h1);
        reg_read_chk(4'd8, 32'd1, "R2 no direction ignored");
        reg_write(4'd3, 32'h4);
        reg_read_chk(4'd8, 32'd1, "R2 go clear ignored");

        // Unlisted size code gives one beat; one latency cycle; odd byte address
        ctx = "R6 odd code";
        rd_seed = 16'hBEEF;
        reg_write(4'd0, 32'hFF);
        reg_write(4'd1, 32'hFFFF_FFFF);
        reg_write(4'd2, 32'h0000_0103);
        reg_write(4'd3, 32'h5);
        wait_idle();
        reg_read_chk(4'd6, {exp_rd[63:48], 16'h0}, "R6 single beat upper");
        reg_read_chk(4'd7, 32'd0, "R8 single beat lower cleared");
        reg_read_chk(4'd9, 32'd0, "R10 unmapped index reads zero");

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule